// File: doc/BRIEF.md
# Signed-Digit Quotient Binary Converter

This block sits beside a digit-recurrence divider. The divider produces one quotient digit per cycle, most significant first. Each digit is -1, 0 or +1. The block turns that redundant stream into a plain binary quotient, and it does the work while the digits arrive. Once the last digit is taken, the binary value is already in a register, so no full-width carry-propagate add follows the recurrence.

Inside, conversion is a subtraction of the negative-digit vector from the positive-digit vector. The carry between positions is not rippled. Two registers are kept instead: the value of the digits so far, and that value minus one. For each digit:

- +1 acts as generate.
- 0 acts as propagate.
- -1 acts as kill.

So every step is a choice between two registers, shifted left with a constant appended. When the divider's final remainder is negative, it asks for a correction together with the last digit, and the block then delivers the decremented value. The result is read as unsigned or as two's complement, modulo 2^QW.

Top module: `qconv_top`

## Requirements
- R1: After reset, and in the cycle after `start`, `quotient` is 0, `ready` is low and `codeError` is low.
- R2: Digit codes are 2'b00 = 0, 2'b01 = +1 and 2'b11 = -1. After each accepted digit d, on the next clock edge, `quotient` becomes (2*previous + d) mod 2^QW. Here "previous" is the value of the digits accepted earlier.
- R3: `ready` rises in the cycle right after the clock edge that accepts the QW-th digit, and `quotient` already holds the final value in that cycle.
- R4: If `fixReq` is high with the QW-th accepted digit, the final `quotient` is (value - 1) mod 2^QW. If `fixReq` is high with any earlier digit, it has no effect.
- R5: Once `ready` is high, it stays high, and further digits (legal or not) change neither `quotient` nor `codeError` until `start`.
- R6: A valid digit with code 2'b10 (while not ready) is discarded and does not count. It sets `codeError`, which holds until `start`.
- R7: `start` takes priority over `digitValid` in the same cycle: the digit is dropped and the block is emptied.
- R8: Cycles with `digitValid` low leave `quotient`, `ready` and the digit count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Empty the converter for a new quotient |
| digitValid | input | 1 | A digit is presented this cycle |
| digitCode | input | 2 | Digit encoding (00=0, 01=+1, 11=-1) |
| fixReq | input | 1 | Correction request, taken with the last digit |
| quotient | output | QW | Binary quotient, partial until ready |
| ready | output | 1 | QW digits have been accepted |
| codeError | output | 1 | An illegal digit code was seen |

## Verification
The corner cases are:

- A run of all -1 digits. It exercises the kill path, where every step reloads from the decremented register. A converter that mixed up the two registers would end at 255 or 0 instead of 1.
- Gaps with no valid digit inside a quotient. A design that counted idle cycles would raise `ready` early.
- A correction request on a digit other than the last. A design that latched it there would return a value off by one.
- An illegal code in the middle of a quotient. A design that counted it would finish one digit short.
- A digit presented together with `start`, and digits presented after `ready`. In both cases the bench checks that the final value is unchanged.

// File: rtl/qconv_pkg.sv
package qconv_pkg;

  typedef enum logic [1:0] {
    DIG_ZERO = 2'b00,
    DIG_POS  = 2'b01,
    DIG_BAD  = 2'b10,
    DIG_NEG  = 2'b11
  } digitKind_e;

  typedef struct packed {
    logic       clearAll;
    logic       stepEn;
    digitKind_e digitKind;
    logic       takeFix;
    logic       fixVal;
  } qconvCtl_t;

  function automatic digitKind_e decodeDigit(input logic [1:0] code);
    case (code)
      2'b00:   decodeDigit = DIG_ZERO;
      2'b01:   decodeDigit = DIG_POS;
      2'b11:   decodeDigit = DIG_NEG;
      default: decodeDigit = DIG_BAD;
    endcase
  endfunction

endpackage

// File: rtl/qconv_ctrl.sv
module qconv_ctrl
  import qconv_pkg::*;
#(
  parameter int QW = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       digitValid,
  input  logic [1:0] digitCode,
  input  logic       fixReq,
  output qconvCtl_t  ctl,
  output logic       ready,
  output logic       codeError
);
  localparam int CW = $clog2(QW + 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(QW);
  localparam logic [CW-1:0] LAST_CNT = CW'(QW - 1);

  logic [CW-1:0] digitCnt;
  digitKind_e    kind;
  logic          isFull;
  logic          badSeen;
  logic          acceptDigit;

  assign kind        = decodeDigit(digitCode);
  assign isFull      = (digitCnt == FULL_CNT);
  assign badSeen     = digitValid && !start && !isFull && (kind == DIG_BAD);
  assign acceptDigit = digitValid && !start && !isFull && (kind != DIG_BAD);

  always_comb begin
    ctl.clearAll  = start;
    ctl.stepEn    = acceptDigit;
    ctl.digitKind = kind;
    ctl.takeFix   = acceptDigit && (digitCnt == LAST_CNT);
    ctl.fixVal    = fixReq;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      digitCnt  <= '0;
      codeError <= 1'b0;
    end else if (start) begin
      digitCnt  <= '0;
      codeError <= 1'b0;
    end else begin
      if (acceptDigit) digitCnt <= digitCnt + CW'(1);
      if (badSeen)     codeError <= 1'b1;
    end
  end

  assign ready = isFull;

  a_r5_ready_holds : assert property (@(posedge clk) disable iff (!rstN)
    ready && !start |=> ready);

  a_r6_illegal_flags : assert property (@(posedge clk) disable iff (!rstN)
    digitValid && !start && !ready && digitCode == 2'b10 |=> codeError);

  a_r6_illegal_not_counted : assert property (@(posedge clk) disable iff (!rstN)
    digitValid && !start && digitCode == 2'b10 |=> $stable(digitCnt));

  a_r8_idle_holds : assert property (@(posedge clk) disable iff (!rstN)
    !digitValid && !start |=> $stable(digitCnt) && $stable(ready));

  a_r1_start_empties : assert property (@(posedge clk) disable iff (!rstN)
    start |=> !ready && !codeError);

endmodule

// File: rtl/qconv_datapath.sv
module qconv_datapath
  import qconv_pkg::*;
#(
  parameter int QW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  qconvCtl_t     ctl,
  output logic [QW-1:0] quotient
);
  logic [QW-1:0] qReg;
  logic [QW-1:0] qmReg;
  logic          useQm;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      qReg  <= '0;
      qmReg <= '1;
      useQm <= 1'b0;
    end else if (ctl.clearAll) begin
      qReg  <= '0;
      qmReg <= '1;
      useQm <= 1'b0;
    end else if (ctl.stepEn) begin
      case (ctl.digitKind)
        DIG_POS: begin
          qReg  <= {qReg[QW-2:0], 1'b1};
          qmReg <= {qReg[QW-2:0], 1'b0};
        end
        DIG_NEG: begin
          qReg  <= {qmReg[QW-2:0], 1'b1};
          qmReg <= {qmReg[QW-2:0], 1'b0};
        end
        default: begin
          qReg  <= {qReg[QW-2:0], 1'b0};
          qmReg <= {qmReg[QW-2:0], 1'b1};
        end
      endcase
      if (ctl.takeFix) useQm <= ctl.fixVal;
    end
  end

  assign quotient = useQm ? qmReg : qReg;

  a_r2_minus_one_tracks : assert property (@(posedge clk) disable iff (!rstN)
    QW'(qReg - qmReg) == QW'(1));

  a_r1_clear_zero : assert property (@(posedge clk) disable iff (!rstN)
    ctl.clearAll |=> quotient == '0);

  a_r8_hold_when_idle : assert property (@(posedge clk) disable iff (!rstN)
    !ctl.stepEn && !ctl.clearAll |=> $stable(quotient));

endmodule

// File: rtl/qconv_top.sv
module qconv_top
  import qconv_pkg::*;
#(
  parameter int QW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic          digitValid,
  input  logic [1:0]    digitCode,
  input  logic          fixReq,
  output logic [QW-1:0] quotient,
  output logic          ready,
  output logic          codeError
);
  qconvCtl_t ctl;

  qconv_ctrl #(.QW(QW)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .digitValid(digitValid),
    .digitCode(digitCode), .fixReq(fixReq), .ctl(ctl),
    .ready(ready), .codeError(codeError)
  );

  qconv_datapath #(.QW(QW)) uPath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .quotient(quotient)
  );

  a_r5_frozen_when_ready : assert property (@(posedge clk) disable iff (!rstN)
    ready && !start |=> $stable(quotient) && $stable(codeError));

endmodule

// File: tb/tb_qconv_top.sv
module tb_qconv_top;
  localparam int QW = 8;
  localparam int MASK = (1 << QW) - 1;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic          digitValid = 1'b0;
  logic [1:0]    digitCode = 2'b00;
  logic          fixReq = 1'b0;
  logic [QW-1:0] quotient;
  logic          ready;
  logic          codeError;

  int checks = 0;
  int fails = 0;
  int model = 0;

  always #2 clk = ~clk;

  qconv_top #(.QW(QW)) dut (
    .clk(clk), .rstN(rstN), .start(start), .digitValid(digitValid),
    .digitCode(digitCode), .fixReq(fixReq), .quotient(quotient),
    .ready(ready), .codeError(codeError)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [1:0] enc(input int d);
    return (d > 0) ? 2'b01 : (d < 0) ? 2'b11 : 2'b00;
  endfunction

  task automatic doStart();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    model = 0;
  endtask

  task automatic feed(input int d, input logic fix);
    @(negedge clk);
    digitValid = 1'b1;
    digitCode  = enc(d);
    fixReq     = fix;
    @(posedge clk);
    #1;
    digitValid = 1'b0;
    fixReq     = 1'b0;
  endtask

  task automatic runWord(input int digs[QW], input logic fixLast, input string req);
    doStart();
    for (int i = 0; i < QW; i++) begin
      feed(digs[i], fixLast && (i == QW - 1));
      model = (model * 2 + digs[i]) & MASK;
      if (i < QW - 1) check({req, " partial"}, int'(quotient), model);
    end
    check({req, " ready R3"}, int'(ready), 1);
    check({req, " final"}, int'(quotient), fixLast ? ((model - 1) & MASK) : model);
  endtask

  task automatic t_reset();
    check("R1 reset quotient", int'(quotient), 0);
    check("R1 reset ready", int'(ready), 0);
    check("R1 reset error", int'(codeError), 0);
  endtask

  task automatic t_patterns();
    int a[QW] = '{1, 1, 1, 1, 1, 1, 1, 1};
    int b[QW] = '{-1, -1, -1, -1, -1, -1, -1, -1};
    int c[QW] = '{1, -1, 1, -1, 0, 1, -1, -1};
    int e[QW] = '{0, 0, 0, 0, 0, 0, 0, 1};
    runWord(a, 1'b0, "R2 all plus");
    check("R2 all plus value", int'(quotient), 255);
    runWord(b, 1'b0, "R2 all minus");
    check("R2 all minus value", int'(quotient), 1);
    runWord(c, 1'b0, "R2 mixed");
    runWord(e, 1'b0, "R2 zeros");
    check("R2 zeros value", int'(quotient), 1);
  endtask

  task automatic t_fix();
    int c[QW] = '{1, 0, -1, 1, 0, 0, 1, -1};
    int z[QW] = '{0, 0, 0, 0, 0, 0, 0, 0};
    runWord(c, 1'b1, "R4 fix last");
    runWord(z, 1'b1, "R4 fix wrap");
    check("R4 fix wrap value", int'(quotient), 255);
    doStart();
    check("R1 start clears fix", int'(quotient), 0);
    for (int i = 0; i < QW; i++) begin
      feed(1, i == 2);
      model = (model * 2 + 1) & MASK;
    end
    check("R4 early fix ignored", int'(quotient), model);
  endtask

  task automatic t_after_ready();
    feed(-1, 1'b0);
    check("R5 digit after ready", int'(quotient), model);
    check("R5 ready held", int'(ready), 1);
    @(negedge clk);
    digitValid = 1'b1;
    digitCode  = 2'b10;
    @(posedge clk);
    #1;
    digitValid = 1'b0;
    check("R5 bad code after ready", int'(codeError), 0);
  endtask

  task automatic t_illegal();
    doStart();
    feed(1, 1'b0);
    model = 1;
    @(negedge clk);
    digitValid = 1'b1;
    digitCode  = 2'b10;
    @(posedge clk);
    #1;
    digitValid = 1'b0;
    check("R6 error set", int'(codeError), 1);
    check("R6 digit discarded", int'(quotient), 1);
    for (int i = 0; i < QW - 1; i++) begin
      check("R6 not counted", int'(ready), 0);
      feed(0, 1'b0);
      model = (model * 2) & MASK;
    end
    check("R6 ready after QW legal", int'(ready), 1);
    check("R6 value", int'(quotient), model);
    check("R6 error held", int'(codeError), 1);
    doStart();
    check("R1 start clears error", int'(codeError), 0);
  endtask

  task automatic t_start_priority();
    doStart();
    feed(1, 1'b0);
    @(negedge clk);
    start      = 1'b1;
    digitValid = 1'b1;
    digitCode  = 2'b01;
    @(posedge clk);
    #1;
    start      = 1'b0;
    digitValid = 1'b0;
    check("R7 start wins", int'(quotient), 0);
    check("R7 ready low", int'(ready), 0);
  endtask

  task automatic t_idle_gaps();
    doStart();
    for (int i = 0; i < QW; i++) begin
      feed((i % 3) - 1, 1'b0);
      model = (model * 2 + (i % 3) - 1) & MASK;
      repeat (2) @(negedge clk);
      if (i < QW - 1) check("R8 gap no ready", int'(ready), 0);
      check("R8 gap holds value", int'(quotient), model);
    end
    check("R8 ready after gaps", int'(ready), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_patterns();
    t_fix();
    t_after_ready();
    t_illegal();
    t_start_priority();
    t_idle_gaps();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 100000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule